// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A single-cycle start pulse supplies the starting column, a three-bit burst-length code and an ordering bit. From the next cycle onward the block presents one column per clock, with a valid flag and a last-beat flag. The burst stays inside an aligned block of columns whose size equals the burst length.

Beats can follow sequential ordering, which is an add with wrap inside the block, or interleaved ordering, which XORs the start column with the beat index. A full-page sequential mode walks across the whole row of columns, wrapping at the top, until a terminate input ends it. Codes that select an unsupported length or ordering raise a one-cycle error pulse and produce no beats. The column width is a parameter: 10, 11 or 12 bits.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after it is released with no start, `valid_o`, `last_o` and `err_o` are low.
- R2: A start with a legal code is registered on a rising edge. That edge presents beat 0 with `col_o` equal to `start_col_i` and `valid_o` high. Each following edge presents the next beat.
- R3: Length code 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `last_o` is high on the final beat only.
- R4: With `interleave_i`=0 and a fixed length L, beat i has its low log2(L) bits equal to (start low bits + i) mod L. The bits above them are equal to the start column.
- R5: With `interleave_i`=1 and a fixed length L, beat i has its low log2(L) bits equal to the start low bits XOR i. The bits above them are equal to the start column.
- R6: Code 111 with `interleave_i`=0 is a full-page burst. Beat i is (start + i) mod 2^COL_W. Beats continue every cycle until `term_i` is high at a rising edge, and the beat presented at that edge carries `last_o`.
- R7: `term_i` has no effect during a fixed-length burst or while no burst is running.
- R8: Codes 100, 101 and 110, and code 111 with `interleave_i`=1, are illegal. An illegal start gives `err_o` high for the one cycle after the start edge and produces no beats.
- R9: On the cycle after a beat with `last_o` high, `valid_o` is low unless a new start was given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst this cycle |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 0 sequential, 1 interleaved |
| term_i | input | 1 | End a full-page burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of the burst |
| err_o | output | 1 | Illegal code seen at start |

## Verification
Beat 0 appears one cycle after the start edge, and each later beat appears one cycle after the one before it. `err_o` appears in the same slot that beat 0 would have taken. A terminate affects the beat registered on the edge where it is sampled. The driver queues the expected column and last flag of each beat before it raises start. The monitor samples on falling edges, so it sees each registered beat half a period after the edge that produced it. Any beat that arrives with an empty queue, and any queue left undrained once a burst ends, is reported as a failure.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Decoded burst configuration
  typedef struct packed {
    logic       legal;
    logic       full;
    logic [1:0] len_log;
  } burst_cfg_t;
endpackage

// File: rtl/burst_decode.sv
module burst_decode
  import burst_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic       ilv_i,
  output burst_cfg_t cfg_o
);
  always_comb begin
    cfg_o = '0;
    case (code_i)
      3'b000, 3'b001, 3'b010, 3'b011: begin
        cfg_o.legal   = 1'b1;
        cfg_o.len_log = code_i[1:0];
      end
      3'b111: begin
        cfg_o.legal = ~ilv_i;
        cfg_o.full  = 1'b1;
      end
      default: cfg_o = '0;
    endcase
  end
endmodule

// File: rtl/burst_addr.sv
module burst_addr #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [1:0]       len_log_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  always_comb begin
    mask_o = full_i ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << len_log_i);
    sum    = base_i + idx_i;
    if (ilv_i) col_o = base_i ^ (idx_i & mask_o);
    else       col_o = (base_i & ~mask_o) | (sum & mask_o);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  localparam logic [COL_W-1:0] IDX_ONE = COL_W'(1);

  burst_cfg_t       cfg_in, cfg_q, cfg_d;
  logic [COL_W-1:0] base_q, base_d, idx_q, idx_d, col_q, col_d;
  logic [COL_W-1:0] col_run, mask_run;
  logic             ilv_q, ilv_d, active_q, active_d;
  logic             valid_q, valid_d, last_q, last_d, err_q, err_d;
  logic             data_en;

  burst_decode u_dec (
    .code_i (len_code_i),
    .ilv_i  (interleave_i),
    .cfg_o  (cfg_in)
  );

  burst_addr #(.COL_W(COL_W)) u_addr (
    .base_i    (base_q),
    .idx_i     (idx_q),
    .len_log_i (cfg_q.len_log),
    .full_i    (cfg_q.full),
    .ilv_i     (ilv_q),
    .mask_o    (mask_run),
    .col_o     (col_run)
  );

  // Next-state logic
  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    idx_d    = idx_q;
    cfg_d    = cfg_q;
    ilv_d    = ilv_q;
    col_d    = col_q;
    valid_d  = 1'b0;
    last_d   = 1'b0;
    err_d    = 1'b0;
    if (start_i) begin
      if (cfg_in.legal) begin
        base_d   = start_col_i;
        cfg_d    = cfg_in;
        ilv_d    = interleave_i;
        col_d    = start_col_i;
        idx_d    = IDX_ONE;
        valid_d  = 1'b1;
        last_d   = ~cfg_in.full && (cfg_in.len_log == 2'd0);
        active_d = ~last_d;
      end else begin
        err_d    = 1'b1;
        active_d = 1'b0;
      end
    end else if (active_q) begin
      col_d    = col_run;
      idx_d    = idx_q + IDX_ONE;
      valid_d  = 1'b1;
      last_d   = cfg_q.full ? term_i : (idx_q == mask_run);
      active_d = ~last_d;
    end
  end

  assign data_en = start_i | active_q;

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      valid_q  <= valid_d;
      last_q   <= last_d;
      err_q    <= err_d;
    end
  end

  // Datapath registers, enabled only when a burst starts or runs
  always_ff @(posedge clk) begin
    if (data_en) begin
      base_q <= base_d;
      idx_q  <= idx_d;
      cfg_q  <= cfg_d;
      ilv_q  <= ilv_d;
      col_q  <= col_d;
    end
  end

  assign col_o   = col_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;
  assign err_o   = err_q;
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             interleave_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o
);
  logic ok_code;
  assign ok_code = (len_code_i[2] == 1'b0) || (len_code_i == 3'b111 && !interleave_i);

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && ok_code |=> valid_o && col_o == $past(start_col_i));

  // R3
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R8
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !ok_code |=> err_o && !valid_o);

  // R9
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !valid_o);

  // R2
  burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && !start_i |=> valid_o);
endmodule

bind sdram_burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .start_col_i  (start_col_i),
  .len_code_i   (len_code_i),
  .interleave_i (interleave_i),
  .col_o        (col_o),
  .valid_o      (valid_o),
  .last_o       (last_o),
  .err_o        (err_o)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  localparam int COL_W = 10;

  typedef struct {
    logic [COL_W-1:0] col;
    logic             last;
    string            req;
  } beat_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             interleave_i = 1'b0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, err_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  beat_t expq[$];

  always #5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] model_col(input logic [COL_W-1:0] s,
      input int i, input int len, input bit ilv, input bit full);
    logic [COL_W-1:0] m, r;
    if (full) return s + COL_W'(i);
    m = COL_W'(len - 1);
    if (ilv) r = (s & ~m) | ((s ^ COL_W'(i)) & m);
    else     r = (s & ~m) | ((s + COL_W'(i)) & m);
    return r;
  endfunction

  // Monitor: compare each beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && valid_o) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected beat", int'(col_o), -1);
      end else begin
        beat_t e;
        e = expq.pop_front();
        check(col_o == e.col, {e.req, " col"}, int'(col_o), int'(e.col));
        check(last_o == e.last, {e.req, " last"}, int'(last_o), int'(e.last));
      end
    end
  end

  // Fixed burst; hold_term drives term during the burst (R7)
  task automatic fixed_burst(input logic [COL_W-1:0] s, input logic [2:0] code,
      input bit ilv, input bit hold_term, input string req);
    int len;
    len = 1 << code;
    for (int i = 0; i < len; i++) begin
      beat_t b;
      b.col = model_col(s, i, len, ilv, 1'b0);
      b.last = (i == len - 1);
      b.req = req;
      expq.push_back(b);
    end
    @(negedge clk);
    start_i = 1'b1; start_col_i = s; len_code_i = code; interleave_i = ilv;
    term_i = hold_term;
    @(negedge clk);
    start_i = 1'b0;
    repeat (len + 1) @(negedge clk);
    term_i = 1'b0;
    check(expq.size() == 0, {req, " drained"}, expq.size(), 0);
    check(!valid_o, "R9 valid low after last", int'(valid_o), 0);
  endtask

  // Full-page burst of n beats (n >= 2)
  task automatic page_burst(input logic [COL_W-1:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      beat_t b;
      b.col = model_col(s, i, 0, 1'b0, 1'b1);
      b.last = (i == n - 1);
      b.req = "R6";
      expq.push_back(b);
    end
    @(negedge clk);
    start_i = 1'b1; start_col_i = s; len_code_i = 3'b111; interleave_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (n - 2) @(negedge clk);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    repeat (2) @(negedge clk);
    check(expq.size() == 0, "R6 drained", expq.size(), 0);
    check(!valid_o, "R9 valid low after terminate", int'(valid_o), 0);
  endtask

  task automatic bad_start(input logic [2:0] code, input bit ilv);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 10'h155; len_code_i = code; interleave_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o == 1'b1, "R8 err pulse", int'(err_o), 1);
    check(valid_o == 1'b0, "R8 no beat", int'(valid_o), 0);
    @(negedge clk);
    check(err_o == 1'b0 && valid_o == 1'b0, "R8 err one cycle, no beats",
          int'({err_o, valid_o}), 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      check(1'b0, "watchdog", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({valid_o, last_o, err_o} == 3'b000, "R1 in reset", int'({valid_o, last_o, err_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({valid_o, last_o, err_o} == 3'b000, "R1 after reset", int'({valid_o, last_o, err_o}), 0);

    // Sequential, all fixed lengths (R2, R3, R4)
    fixed_burst(10'h005, 3'b000, 1'b0, 1'b0, "R3 len1");
    fixed_burst(10'h00D, 3'b001, 1'b0, 1'b0, "R4 seq len2");
    fixed_burst(10'h01E, 3'b010, 1'b0, 1'b0, "R4 seq len4");
    fixed_burst(10'h02D, 3'b011, 1'b0, 1'b0, "R4 seq len8");
    fixed_burst(10'h3FF, 3'b011, 1'b0, 1'b0, "R2 seq len8 top");
    // Interleaved (R5)
    fixed_burst(10'h00D, 3'b001, 1'b1, 1'b0, "R5 ilv len2");
    fixed_burst(10'h01E, 3'b010, 1'b1, 1'b0, "R5 ilv len4");
    fixed_burst(10'h02D, 3'b011, 1'b1, 1'b0, "R5 ilv len8");
    // Terminate ignored in fixed bursts (R7)
    fixed_burst(10'h01A, 3'b011, 1'b0, 1'b1, "R7 term ignored seq");
    fixed_burst(10'h013, 3'b010, 1'b1, 1'b1, "R7 term ignored ilv");
    // Terminate while idle (R7)
    @(negedge clk); term_i = 1'b1;
    repeat (3) @(negedge clk);
    check(!valid_o && !last_o, "R7 idle term", int'({valid_o, last_o}), 0);
    term_i = 1'b0;
    // Full page (R6), including wrap across the row
    page_burst(10'h3FC, 8);
    page_burst(10'h064, 3);
    page_burst(10'h000, 2);
    // Illegal codes (R8)
    bad_start(3'b100, 1'b0);
    bad_start(3'b101, 1'b1);
    bad_start(3'b110, 1'b0);
    bad_start(3'b111, 1'b1);
    // Legal burst still works after errors
    fixed_burst(10'h0F6, 3'b010, 1'b0, 1'b0, "R2 after error");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule